// File: doc/BRIEF.md
# Burst Profile Frame Encoder

This block assembles one upstream burst at a time. A small table of six burst profiles is written through a plain configuration port. Each profile holds a payload byte count, a parity byte count, a preamble length and pattern, a modulation choice (QPSK or 16QAM), a randomizer seed and a randomizer enable. A start request names one profile. The block then pulls exactly that many payload bytes from an input byte stream and appends GF(256) parity bytes. It whitens the resulting bit stream with a seeded 15-bit LFSR, applies differential quadrant encoding and puts the raw preamble symbols in front. Symbols leave on a valid/ready stream with a last flag.

All three streams use valid/ready, and a transfer happens on a clock edge where both are high. The symbol output honours back-pressure: while `sym_ready` is low, the pending symbol and its flag are held unchanged and nothing is lost. The payload input is pulled one byte at a time, and `in_valid` may drop between bytes. A new start is taken only while the block is idle, which is after the symbol flagged last has been accepted. Pulse shaping, frequency conversion and conversion to analog happen downstream.

Top module: `bpfe_burst_encoder`

## Requirements
- R1: After reset, `start_ready` is 1, `sym_valid` is 0 and `in_ready` is 0.
- R2: Profiles 0..5 are written when `cfg_we` is 1, using the `cfg_*` field inputs with `cfg_sel` as the index. A write with `cfg_sel` of 6 or 7 changes no profile. A rewritten profile applies from the next burst started with it.
- R3: A start is taken when `start_valid` and `start_ready` are both 1. `start_ready` is 1 only while idle. A start naming profile 6 or 7 is consumed and discarded: no symbol follows and `start_ready` stays 1.
- R4: A burst reads exactly `pay_len` payload bytes (1..255). `in_ready` is 0 at every other time.
- R5: `par_len` parity bytes (0..8, 0 meaning FEC off) follow the payload, parity byte k first for k = 0 upward. Parity byte k is the payload polynomial evaluated at alpha^(k+1) in GF(256), where the field is generated by 0x11D and alpha = 0x02. In that evaluation the first payload byte is the coefficient of the highest power.
- R6: Bytes are split MSB first, and the first bit taken becomes the most significant bit of its symbol. QPSK symbols use `sym_data[1:0]` with `sym_data[3:2]` = 0. 16QAM symbols use all four bits.
- R7: The randomizer is an LFSR s[14:0] loaded with the profile seed at burst start. For every data or parity bit, in order, r = s[14] XOR s[13], the bit is XORed with r when randomizing is enabled, and then s becomes {s[13:0], r}. With randomizing disabled the bits pass unchanged.
- R8: The differential reference quadrant is 0 at burst start. For each data symbol, u is its upper two bits after randomizing. The new quadrant is (previous + u) mod 4 and is sent in the upper two bits. In 16QAM the lower two bits pass through unchanged.
- R9: `pre_len` preamble symbols lead the burst, taken from `pre_pat` starting at bit 31 and moving downward. Preamble bits are neither randomized nor differentially encoded, and they do not advance the LFSR. `pre_len` times the bits per symbol must not exceed 32.
- R10: `sym_last` is 1 on the final symbol of the burst only. `start_ready` rises in the cycle after that symbol is accepted.
- R11: While `sym_valid` is 1 and `sym_ready` is 0, `sym_valid`, `sym_data` and `sym_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Profile write strobe |
| cfg_sel | input | 3 | Profile index to write |
| cfg_pay_len | input | 8 | Payload length in bytes |
| cfg_par_len | input | 4 | Parity byte count |
| cfg_pre_len | input | 5 | Preamble length in symbols |
| cfg_pre_pat | input | 32 | Preamble pattern, sent from bit 31 down |
| cfg_qam16 | input | 1 | 1 selects 16QAM, 0 selects QPSK |
| cfg_rand_en | input | 1 | Randomizer enable |
| cfg_seed | input | 15 | Randomizer seed |
| start_valid | input | 1 | Burst start request |
| start_ready | output | 1 | Idle, start can be taken |
| start_prof | input | 3 | Profile index for the burst |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte wanted |
| in_data | input | 8 | Payload byte |
| sym_valid | output | 1 | Symbol valid |
| sym_ready | input | 1 | Symbol accepted downstream |
| sym_data | output | 4 | Symbol value |
| sym_last | output | 1 | Final symbol of the burst |

## Verification
The first preamble symbol is presented in the cycle after the start is accepted. The first data symbol of each byte appears one cycle after that byte is accepted, or after the block takes it from the parity register, and the following symbols of the byte come out one per accepted handshake. `start_ready` returns one cycle after the last symbol is taken. Because back-pressure and input gaps move these times around, the bench compares each symbol at the handshake where it leaves, sampling mid-cycle before the edge that completes the transfer. Timing-fixed points such as `start_ready` after a start, or the idle state after a discarded start, are sampled one cycle after the edge that causes them.

// File: rtl/bpfe_pkg.sv
package bpfe_pkg;
  localparam int NPROF   = 6;
  localparam int PSEL_W  = $clog2(NPROF + 1);
  localparam int PAY_W   = 8;
  localparam int MAX_PAR = 8;
  localparam int PAR_W   = $clog2(MAX_PAR + 1);
  localparam int PRE_W   = 5;
  localparam int PAT_W   = 32;
  localparam int SEED_W  = 15;
  localparam int BYTE_W  = 8;
  localparam int SCNT_W  = 3;
  localparam logic [8:0] GF_POLY = 9'h11D;

  typedef struct packed {
    logic [PAY_W-1:0]  pay_len;
    logic [PAR_W-1:0]  par_len;
    logic [PRE_W-1:0]  pre_len;
    logic [PAT_W-1:0]  pre_pat;
    logic              qam16;
    logic              rand_en;
    logic [SEED_W-1:0] seed;
  } prof_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_FETCH, ST_SEND} st_t;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = '0;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa[7] ? ((aa << 1) ^ GF_POLY[7:0]) : (aa << 1);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf_alpha_pow(input int n);
    logic [7:0] v;
    v = 8'h01;
    for (int i = 0; i < n; i++) v = gf_mul(v, 8'h02);
    return v;
  endfunction
endpackage

// File: rtl/bpfe_profile_store.sv
module bpfe_profile_store
  import bpfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PSEL_W-1:0] wsel,
  input  prof_t             wdata,
  input  logic [PSEL_W-1:0] rsel,
  output prof_t             rdata
);
  prof_t ent_all [NPROF];

  for (genvar g = 0; g < NPROF; g++) begin : g_ent
    prof_t ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else if (we && (wsel == PSEL_W'(g))) ent_q <= wdata;
    end
    assign ent_all[g] = ent_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPROF; i++)
      if (rsel == PSEL_W'(i)) rdata = ent_all[i];
  end
endmodule

// File: rtl/bpfe_rs_parity.sv
module bpfe_rs_parity
  import bpfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              absorb,
  input  logic [BYTE_W-1:0] din,
  input  logic              shift,
  output logic [BYTE_W-1:0] head
);
  logic [BYTE_W-1:0] par_all [MAX_PAR];

  for (genvar k = 0; k < MAX_PAR; k++) begin : g_par
    localparam logic [7:0] ROOT = gf_alpha_pow(k + 1);
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] shin;
    logic [BYTE_W-1:0] nxt;
    if (k == MAX_PAR - 1) begin : g_tail
      assign shin = '0;
    end else begin : g_mid
      assign shin = par_all[k+1];
    end
    always_comb begin
      nxt = q;
      if (clr)         nxt = '0;
      else if (absorb) nxt = gf_mul(q, ROOT) ^ din;
      else if (shift)  nxt = shin;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end
    assign par_all[k] = q;
  end

  assign head = par_all[0];

  // R5: a byte is never absorbed in the same cycle a parity byte is drained
  p_absorb_shift_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(absorb && shift));
endmodule

// File: rtl/bpfe_sym_mapper.sv
module bpfe_sym_mapper
  import bpfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEED_W-1:0] seed,
  input  logic              step,
  input  logic              qam16,
  input  logic              rand_en,
  input  logic [3:0]        raw,
  output logic [3:0]        sym
);
  logic [SEED_W-1:0] lfsr_q, lfsr_n;
  logic [1:0]        quad_q, quad_n;

  always_comb begin
    logic [SEED_W-1:0] s;
    logic [3:0]        x;
    logic              r;
    logic [1:0]        u;
    s = lfsr_q;
    x = '0;
    r = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i < 2 || qam16) begin
        r = s[SEED_W-1] ^ s[SEED_W-2];
        x = {x[2:0], raw[3-i] ^ (rand_en & r)};
        s = {s[SEED_W-2:0], r};
      end
    end
    u      = qam16 ? x[3:2] : x[1:0];
    quad_n = quad_q + u;
    lfsr_n = s;
    sym    = qam16 ? {quad_n, x[1:0]} : {2'b00, quad_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '0;
      quad_q <= '0;
    end else if (load) begin
      lfsr_q <= seed;
      quad_q <= '0;
    end else if (step) begin
      lfsr_q <= lfsr_n;
      quad_q <= quad_n;
    end
  end

  // R8: the reference is never reloaded while a data symbol is leaving
  p_load_step_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step));
endmodule

// File: rtl/bpfe_burst_encoder.sv
module bpfe_burst_encoder
  import bpfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PSEL_W-1:0] cfg_sel,
  input  logic [PAY_W-1:0]  cfg_pay_len,
  input  logic [PAR_W-1:0]  cfg_par_len,
  input  logic [PRE_W-1:0]  cfg_pre_len,
  input  logic [PAT_W-1:0]  cfg_pre_pat,
  input  logic              cfg_qam16,
  input  logic              cfg_rand_en,
  input  logic [SEED_W-1:0] cfg_seed,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [PSEL_W-1:0] start_prof,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [3:0]        sym_data,
  output logic              sym_last
);
  st_t               st_q;
  prof_t             cfg_w, prof_rd;
  logic              qam_q, ren_q;
  logic [PAT_W-1:0]  pre_sh_q;
  logic [PRE_W-1:0]  pre_cnt_q;
  logic [PAY_W-1:0]  pay_left_q;
  logic [PAR_W-1:0]  par_left_q;
  logic [BYTE_W-1:0] byte_q;
  logic [SCNT_W-1:0] scnt_q;
  logic [BYTE_W-1:0] par_head;
  logic [3:0]        map_sym, pre_sym;
  logic              start_fire, prof_ok, load, in_fire, par_take, sym_fire, final_sym;
  logic [SCNT_W-1:0] syms_per_byte;

  always_comb begin
    cfg_w.pay_len = cfg_pay_len;
    cfg_w.par_len = cfg_par_len;
    cfg_w.pre_len = cfg_pre_len;
    cfg_w.pre_pat = cfg_pre_pat;
    cfg_w.qam16   = cfg_qam16;
    cfg_w.rand_en = cfg_rand_en;
    cfg_w.seed    = cfg_seed;
  end

  bpfe_profile_store u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wsel(cfg_sel), .wdata(cfg_w),
    .rsel(start_prof), .rdata(prof_rd)
  );

  assign start_ready   = (st_q == ST_IDLE);
  assign start_fire    = start_valid && start_ready;
  assign prof_ok       = (start_prof < PSEL_W'(NPROF));
  assign load          = start_fire && prof_ok;
  assign in_ready      = (st_q == ST_FETCH) && (pay_left_q != '0);
  assign in_fire       = in_valid && in_ready;
  assign par_take      = (st_q == ST_FETCH) && (pay_left_q == '0) && (par_left_q != '0);
  assign sym_valid     = (st_q == ST_PRE) || (st_q == ST_SEND);
  assign sym_fire      = sym_valid && sym_ready;
  assign final_sym     = (st_q == ST_SEND) && (scnt_q == SCNT_W'(1)) &&
                         (pay_left_q == '0) && (par_left_q == '0);
  assign sym_last      = final_sym;
  assign syms_per_byte = qam_q ? SCNT_W'(2) : SCNT_W'(4);
  assign pre_sym       = qam_q ? pre_sh_q[PAT_W-1 -: 4] : {2'b00, pre_sh_q[PAT_W-1 -: 2]};
  assign sym_data      = (st_q == ST_PRE) ? pre_sym : map_sym;

  bpfe_rs_parity u_parity (
    .clk(clk), .rst_n(rst_n), .clr(load), .absorb(in_fire), .din(in_data),
    .shift(par_take), .head(par_head)
  );

  bpfe_sym_mapper u_mapper (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(prof_rd.seed),
    .step((st_q == ST_SEND) && sym_fire), .qam16(qam_q), .rand_en(ren_q),
    .raw(byte_q[BYTE_W-1 -: 4]), .sym(map_sym)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      qam_q      <= 1'b0;
      ren_q      <= 1'b0;
      pre_sh_q   <= '0;
      pre_cnt_q  <= '0;
      pay_left_q <= '0;
      par_left_q <= '0;
      byte_q     <= '0;
      scnt_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (load) begin
          qam_q      <= prof_rd.qam16;
          ren_q      <= prof_rd.rand_en;
          pre_sh_q   <= prof_rd.pre_pat;
          pre_cnt_q  <= prof_rd.pre_len;
          pay_left_q <= prof_rd.pay_len;
          par_left_q <= prof_rd.par_len;
          st_q       <= (prof_rd.pre_len != '0) ? ST_PRE : ST_FETCH;
        end
        ST_PRE: if (sym_fire) begin
          pre_sh_q  <= qam_q ? (pre_sh_q << 4) : (pre_sh_q << 2);
          pre_cnt_q <= pre_cnt_q - 1'b1;
          if (pre_cnt_q == PRE_W'(1)) st_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (in_fire) begin
            byte_q     <= in_data;
            pay_left_q <= pay_left_q - 1'b1;
            scnt_q     <= syms_per_byte;
            st_q       <= ST_SEND;
          end else if (par_take) begin
            byte_q     <= par_head;
            par_left_q <= par_left_q - 1'b1;
            scnt_q     <= syms_per_byte;
            st_q       <= ST_SEND;
          end else if (pay_left_q == '0) begin
            st_q <= ST_IDLE;
          end
        end
        ST_SEND: if (sym_fire) begin
          byte_q <= qam_q ? (byte_q << 4) : (byte_q << 2);
          scnt_q <= scnt_q - 1'b1;
          if (scnt_q == SCNT_W'(1)) st_q <= final_sym ? ST_IDLE : ST_FETCH;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11: a stalled symbol keeps its value and flag
  p_sym_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data) && $stable(sym_last)));

  // R10: taking the last symbol returns the block to idle
  p_last_frees_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready && sym_last) |=> (start_ready && !sym_valid));

  // R3: no start is taken while symbols are pending
  p_start_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> !start_ready);

  // R4: payload is only pulled between symbols
  p_in_gap_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !sym_valid);
endmodule

// File: tb/test_bpfe_burst_encoder.sv
`timescale 1ns/1ps
module test_bpfe_burst_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_pay_len = '0;
  logic [3:0]  cfg_par_len = '0;
  logic [4:0]  cfg_pre_len = '0;
  logic [31:0] cfg_pre_pat = '0;
  logic        cfg_qam16 = 1'b0, cfg_rand_en = 1'b0;
  logic [14:0] cfg_seed = '0;
  logic        start_valid = 1'b0, start_ready;
  logic [2:0]  start_prof = '0;
  logic        in_valid = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        sym_valid, sym_ready = 1'b0, sym_last;
  logic [3:0]  sym_data;

  always #2 clk = ~clk;

  bpfe_burst_encoder i_bpfe_burst_encoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_pay_len(cfg_pay_len), .cfg_par_len(cfg_par_len), .cfg_pre_len(cfg_pre_len),
    .cfg_pre_pat(cfg_pre_pat), .cfg_qam16(cfg_qam16), .cfg_rand_en(cfg_rand_en),
    .cfg_seed(cfg_seed), .start_valid(start_valid), .start_ready(start_ready),
    .start_prof(start_prof), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data), .sym_last(sym_last)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  int ready_pct = 100, in_pct = 100;
  string cur_tag = "R6";

  int          b_pay [6], b_par [6], b_pre [6];
  logic [31:0] b_pat [6];
  bit          b_q16 [6], b_ren [6];
  logic [14:0] b_seed [6];

  logic [7:0] feed_q [$];
  logic [4:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    int r;
    r = 0;
    for (int i = 0; i < 8; i++) if (b[i]) r = r ^ (int'(a) << i);
    for (int i = 14; i >= 8; i--) if (r[i]) r = r ^ (32'h11D << (i - 8));
    return r[7:0];
  endfunction

  // Behavioural model: expected {last,data} list for one burst
  task automatic model_burst(input int p, input logic [7:0] pl [$]);
    logic [7:0]  bytes [$];
    bit          bits [$];
    logic [14:0] s;
    int bps, q;
    bps = b_q16[p] ? 4 : 2;
    for (int i = 0; i < b_pre[p] * bps; i++) bits.push_back(b_pat[p][31 - i]);
    for (int i = 0; i < bits.size(); i += bps) begin
      int v;
      v = 0;
      for (int j = 0; j < bps; j++) v = v * 2 + int'(bits[i + j]);
      exp_q.push_back({1'b0, v[3:0]});
    end
    bytes = pl;
    for (int k = 0; k < b_par[p]; k++) begin
      logic [7:0] root, acc;
      root = 8'h01;
      acc  = 8'h00;
      for (int e = 0; e <= k; e++) root = bmul(root, 8'h02);
      foreach (pl[j]) acc = bmul(acc, root) ^ pl[j];
      bytes.push_back(acc);
    end
    s = b_seed[p];
    q = 0;
    bits.delete();
    foreach (bytes[j])
      for (int b = 7; b >= 0; b--) begin
        bit r;
        r = s[14] ^ s[13];
        s = {s[13:0], r};
        bits.push_back(bytes[j][b] ^ (b_ren[p] & r));
      end
    for (int i = 0; i < bits.size(); i += bps) begin
      int v, u, o;
      v = 0;
      for (int j = 0; j < bps; j++) v = v * 2 + int'(bits[i + j]);
      u = (bps == 4) ? (v >> 2) : v;
      q = (q + u) % 4;
      o = (bps == 4) ? (q * 4 + (v & 3)) : q;
      exp_q.push_back({(i + bps == bits.size()), o[3:0]});
    end
    foreach (pl[j]) feed_q.push_back(pl[j]);
  endtask

  // Symbol monitor: compare every accepted symbol
  always @(negedge clk) begin
    sym_ready = (ready_pct >= 100) ? 1'b1 : ($urandom_range(99) < ready_pct);
    #1;
    if (rst_n && sym_valid && sym_ready) begin
      if (exp_q.size() == 0) chk(0, "R10 symbol after burst end", int'(sym_data), 0);
      else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        chk(sym_data == e[3:0], cur_tag, int'(sym_data), int'(e[3:0]));
        chk(sym_last == e[4], "R10 last flag", int'(sym_last), int'(e[4]));
      end
    end
  end

  // Payload feeder
  bit in_pend = 0;
  always @(negedge clk) begin
    if (in_pend) begin
      void'(feed_q.pop_front());
      in_pend = 0;
    end
    if (feed_q.size() != 0 && $urandom_range(99) < in_pct) begin
      in_valid = 1'b1;
      in_data  = feed_q[0];
    end else begin
      in_valid = 1'b0;
      in_data  = '0;
    end
    #1;
    in_pend = in_valid && in_ready && rst_n;
  end

  task automatic cfg_write(input int idx, input int pay, input int par, input int pre,
                           input logic [31:0] pat, input bit q16, input bit ren, input logic [14:0] sd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(idx); cfg_pay_len = 8'(pay); cfg_par_len = 4'(par);
    cfg_pre_len = 5'(pre); cfg_pre_pat = pat; cfg_qam16 = q16; cfg_rand_en = ren; cfg_seed = sd;
    if (idx < 6) begin
      b_pay[idx] = pay; b_par[idx] = par; b_pre[idx] = pre; b_pat[idx] = pat;
      b_q16[idx] = q16; b_ren[idx] = ren; b_seed[idx] = sd;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_burst(input int p);
    @(negedge clk);
    start_valid = 1'b1;
    start_prof  = 3'(p);
    #1;
    while (!start_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic run_burst(input int p, input logic [7:0] pl [$], input string tag);
    cur_tag = tag;
    model_burst(p, pl);
    start_burst(p);
    #1;
    chk(start_ready == 1'b0, "R3 start_ready low while busy", int'(start_ready), 0);
    do begin
      @(posedge clk);
      #1;
    end while (exp_q.size() != 0 || !start_ready);
    chk(exp_q.size() == 0 && feed_q.size() == 0, "R4 payload count", feed_q.size(), 0);
    chk(in_ready == 1'b0, "R4 in_ready idle", int'(in_ready), 0);
  endtask

  function automatic void rand_payload(input int n, ref logic [7:0] pl [$]);
    pl.delete();
    for (int i = 0; i < n; i++) pl.push_back(8'($urandom));
  endfunction

  initial begin
    logic [7:0] pl [$];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(start_ready == 1'b1, "R1 start_ready", int'(start_ready), 1);
    chk(sym_valid == 1'b0, "R1 sym_valid", int'(sym_valid), 0);
    chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);

    cfg_write(0, 3, 0, 0, 32'h0, 0, 0, 15'h1234);
    cfg_write(1, 16, 2, 8, 32'hCC33A5F0, 0, 1, 15'h4A5F);
    cfg_write(2, 12, 8, 8, 32'h1234ABCD, 1, 1, 15'h00A9);
    cfg_write(3, 5, 0, 3, 32'hF0A50000, 1, 0, 15'h0001);
    cfg_write(4, 1, 1, 16, 32'hFFFF0000, 0, 1, 15'h7FFF);
    cfg_write(5, 40, 4, 4, 32'h96000000, 0, 1, 15'h0001);
    cfg_write(6, 99, 3, 2, 32'hDEADBEEF, 1, 1, 15'h5555);

    // R8: 0x1B gives increments 0,1,2,3 -> quadrants 0,1,3,2
    pl = '{8'h1B, 8'hE4, 8'h00};
    run_burst(0, pl, "R8 QPSK differential");
    rand_payload(16, pl);
    run_burst(1, pl, "R7 QPSK randomized with parity");
    rand_payload(12, pl);
    run_burst(2, pl, "R5 16QAM eight parity bytes");
    rand_payload(5, pl);
    run_burst(3, pl, "R6 16QAM plain");
    pl = '{8'hA7};
    run_burst(4, pl, "R9 32-bit preamble, one byte");

    ready_pct = 50; in_pct = 60;
    rand_payload(40, pl);
    run_burst(5, pl, "R11 back-pressure");
    rand_payload(12, pl);
    run_burst(2, pl, "R11 16QAM back-pressure");
    rand_payload(3, pl);
    run_burst(0, pl, "R2 profile 0 after sel 6 write");

    // R3: a start naming profile 7 is discarded
    start_burst(7);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      #1;
      chk(sym_valid == 1'b0 && start_ready == 1'b1, "R3 discarded start", int'(sym_valid), 0);
    end

    // R2: rewritten profile applies to the next burst
    ready_pct = 100; in_pct = 100;
    cfg_write(1, 7, 3, 2, 32'h6C000000, 1, 1, 15'h2B3C);
    rand_payload(7, pl);
    run_burst(1, pl, "R2 rewritten profile");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule